// File: doc/BRIEF.md
# Wide-to-narrow pipelined bus bridge

This block joins a pipelined bus master whose data port is 32 bits wide with byte-wide select lanes to a pipelined slave bus whose data port is 16 bits wide and has no select lanes. Each wide access is accepted once and turned into one, two or more 16-bit transfers. The bridge then gives the master a single acknowledge and, for reads, the 32-bit word assembled from the returned halves. Byte lanes follow little-endian order: select bit 0 and data bits 7:0 are the lowest byte address.

The upstream address is a 21-bit byte address. Its two lowest bits are not used. The downstream address is a 20-bit half-word address built from upstream bits 20:2 followed by the half index (0 = low half, 1 = high half). The bridge does no address decoding. Only one wide access is in flight at a time: the bridge raises its upstream stall from the moment it accepts a request until it acknowledges it. A write that updates exactly one byte of a half-word reads that half-word first, merges the byte into it, and writes the result back.

Top module: `wb_narrow_bridge`

## Requirements
- R1: While reset is high and in the first cycle after reset, `up_ack`, `up_stall`, `dn_cyc` and `dn_stb` are all low.
- R2: A read with select 4'b1111 makes two narrow reads. The low half-word address (bit 0 = 0) comes first, then that address + 1. `up_rdat` returns {second data, first data}.
- R3: When only one half-word has select bits set, the bridge makes exactly one narrow transfer to that half. In a read, the unselected 16-bit half of `up_rdat` is zero.
- R4: When both select bits of a half-word are set in a write, that half is written with one narrow write and no narrow read beforehand.
- R5: When exactly one select bit of a half-word is set in a write, the bridge reads that half, then writes it back with the selected byte replaced. The other byte keeps its old value.
- R6: `up_ack` goes high for exactly one cycle per accepted access. That cycle directly follows the cycle of the last `dn_ack` belonging to the access, and `dn_cyc` is low during it.
- R7: `up_stall` is high from the cycle after a request is accepted until the acknowledge cycle. Holding `up_stb` high during that time starts no further access.
- R8: While `dn_stall` is high, `dn_stb` stays asserted, and `dn_adr`, `dn_we` and `dn_wdat` stay stable until the transfer is taken.
- R9: An access with select 4'b0000 is acknowledged without any narrow transfer, and `up_rdat` is zero.
- R10: Upstream address bits 1:0 have no effect. `dn_adr` equals {`up_adr`[20:2], half index}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_i | input | 1 | Synchronous reset, active high |
| up_cyc | input | 1 | Upstream bus cycle |
| up_stb | input | 1 | Upstream strobe |
| up_we | input | 1 | Upstream write enable |
| up_adr | input | 21 | Upstream byte address |
| up_sel | input | 4 | Upstream byte selects, bit n = byte n |
| up_wdat | input | 32 | Upstream write data |
| up_rdat | output | 32 | Upstream read data |
| up_ack | output | 1 | Upstream acknowledge |
| up_stall | output | 1 | Upstream stall |
| dn_cyc | output | 1 | Downstream bus cycle |
| dn_stb | output | 1 | Downstream strobe |
| dn_we | output | 1 | Downstream write enable |
| dn_adr | output | 20 | Downstream half-word address |
| dn_wdat | output | 16 | Downstream write data |
| dn_rdat | input | 16 | Downstream read data |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_stall | input | 1 | Downstream stall |

## Verification
Two events can fall in the same cycle: a new upstream strobe can arrive while a split or read-modify-write sequence is still issuing its narrow transfers, and a narrow stall can hit the write-back of a merged byte. The bench provokes the first by holding `up_stb` high until the acknowledge. It passes only if exactly two narrow reads and one acknowledge result. It provokes the second by replaying the whole vector table with a periodic `dn_stall`. That run must yield the same data, the same transfer counts and the same address order as the run without stalls, and a final read-back shows that the merged bytes survived.

// File: rtl/wb_narrow_bridge.sv
module wb_narrow_bridge #(
  parameter int UP_AW = 21,
  parameter int DN_AW = UP_AW - 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             up_cyc,
  input  logic             up_stb,
  input  logic             up_we,
  input  logic [UP_AW-1:0] up_adr,
  input  logic [3:0]       up_sel,
  input  logic [31:0]      up_wdat,
  output logic [31:0]      up_rdat,
  output logic             up_ack,
  output logic             up_stall,
  output logic             dn_cyc,
  output logic             dn_stb,
  output logic             dn_we,
  output logic [DN_AW-1:0] dn_adr,
  output logic [15:0]      dn_wdat,
  input  logic [15:0]      dn_rdat,
  input  logic             dn_ack,
  input  logic             dn_stall
);
  localparam int BW = DN_AW - 1;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_t;

  st_t         st;
  logic [BW-1:0] base_q;
  logic        we_q, half_q, rd_q, hi_need_q;
  logic [3:0]  sel_q;
  logic [31:0] wd_q, rb_q;

  logic [1:0]  cur_sel;
  logic [15:0] cur_wd, cur_rb;
  logic [1:0]  need;

  assign need    = {|up_sel[3:2], |up_sel[1:0]};
  assign cur_sel = half_q ? sel_q[3:2] : sel_q[1:0];
  assign cur_wd  = half_q ? wd_q[31:16] : wd_q[15:0];
  assign cur_rb  = half_q ? rb_q[31:16] : rb_q[15:0];

  assign dn_wdat  = {cur_sel[1] ? cur_wd[15:8] : cur_rb[15:8],
                     cur_sel[0] ? cur_wd[7:0]  : cur_rb[7:0]};
  assign dn_adr   = {base_q, half_q};
  assign dn_we    = we_q & ~rd_q;
  assign dn_stb   = (st == S_ISSUE);
  assign dn_cyc   = (st == S_ISSUE) || (st == S_WAIT);
  assign up_stall = (st != S_IDLE);
  assign up_ack   = (st == S_DONE);
  assign up_rdat  = rb_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st        <= S_IDLE;
      base_q    <= '0;
      we_q      <= 1'b0;
      half_q    <= 1'b0;
      rd_q      <= 1'b0;
      hi_need_q <= 1'b0;
      sel_q     <= '0;
      wd_q      <= '0;
      rb_q      <= '0;
    end else begin
      case (st)
        S_IDLE: if (up_cyc && up_stb) begin
          base_q    <= up_adr[UP_AW-1:2];
          we_q      <= up_we;
          sel_q     <= up_sel;
          wd_q      <= up_wdat;
          rb_q      <= '0;
          hi_need_q <= need[1];
          half_q    <= ~need[0];
          rd_q      <= ~up_we | (need[0] ? ^up_sel[1:0] : ^up_sel[3:2]);
          st        <= (need == 2'b00) ? S_DONE : S_ISSUE;
        end
        S_ISSUE: if (!dn_stall) st <= S_WAIT;
        S_WAIT: if (dn_ack) begin
          if (rd_q) begin
            if (half_q) rb_q[31:16] <= dn_rdat;
            else        rb_q[15:0]  <= dn_rdat;
          end
          if (we_q && rd_q) begin
            rd_q <= 1'b0;
            st   <= S_ISSUE;
          end else if (!half_q && hi_need_q) begin
            half_q <= 1'b1;
            rd_q   <= ~we_q | ^sel_q[3:2];
            st     <= S_ISSUE;
          end else begin
            st <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    rst_i |=> (!up_ack && !dn_cyc && !dn_stb && !up_stall));

  a_r6_ack_single: assert property (@(posedge clk_i) disable iff (rst_i)
    up_ack |=> !up_ack);

  a_r6_ack_bus_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    up_ack |-> !dn_cyc);

  a_r7_stall_busy: assert property (@(posedge clk_i) disable iff (rst_i)
    dn_cyc |-> up_stall);

  a_r8_hold_stalled: assert property (@(posedge clk_i) disable iff (rst_i)
    (dn_stb && dn_stall) |=> (dn_stb && $stable(dn_adr) && $stable(dn_we) && $stable(dn_wdat)));
endmodule

// File: tb/tb_wb_narrow_bridge.sv
module tb_wb_narrow_bridge;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        up_cyc = 0, up_stb = 0, up_we = 0;
  logic [20:0] up_adr = '0;
  logic [3:0]  up_sel = '0;
  logic [31:0] up_wdat = '0;
  logic [31:0] up_rdat;
  logic        up_ack, up_stall;
  logic        dn_cyc, dn_stb, dn_we, dn_ack, dn_stall;
  logic [19:0] dn_adr;
  logic [15:0] dn_wdat, dn_rdat;
  logic        stall_en = 0;

  int checks = 0, errors = 0, cyc = 0;
  int n_rd, n_wr, n_log, n_ack, ack_cyc, last_dn;
  logic [19:0] log_adr [4];
  logic        log_we  [4];
  logic [15:0] smem [16];
  logic [7:0]  refm [32];

  wb_narrow_bridge dut (
    .clk_i(clk), .rst_i(rst),
    .up_cyc(up_cyc), .up_stb(up_stb), .up_we(up_we), .up_adr(up_adr),
    .up_sel(up_sel), .up_wdat(up_wdat), .up_rdat(up_rdat), .up_ack(up_ack),
    .up_stall(up_stall), .dn_cyc(dn_cyc), .dn_stb(dn_stb), .dn_we(dn_we),
    .dn_adr(dn_adr), .dn_wdat(dn_wdat), .dn_rdat(dn_rdat), .dn_ack(dn_ack),
    .dn_stall(dn_stall)
  );

  assign dn_stall = stall_en && (cyc % 3 != 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      dn_ack <= 1'b0;
      dn_rdat <= '0;
    end else begin
      dn_ack <= dn_stb && !dn_stall;
      if (dn_stb && !dn_stall) begin
        if (dn_we) smem[dn_adr[3:0]] <= dn_wdat;
        dn_rdat <= smem[dn_adr[3:0]];
        if (dn_we) n_wr <= n_wr + 1; else n_rd <= n_rd + 1;
        if (n_log < 4) begin
          log_adr[n_log] <= dn_adr;
          log_we[n_log]  <= dn_we;
          n_log <= n_log + 1;
        end
      end
      if (dn_ack) last_dn <= cyc;
      if (up_ack) begin
        n_ack <= n_ack + 1;
        ack_cyc <= cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // fields: we[41] adr[40:36] sel[35:32] wdat[31:0]
  localparam logic [41:0] VEC [13] = '{
    {1'b0, 5'd0,  4'hF, 32'h0},
    {1'b1, 5'd4,  4'hF, 32'h11223344},
    {1'b0, 5'd4,  4'hF, 32'h0},
    {1'b1, 5'd8,  4'h3, 32'hAABBCCDD},
    {1'b1, 5'd8,  4'h4, 32'h0055AA00},
    {1'b0, 5'd8,  4'hF, 32'h0},
    {1'b0, 5'd12, 4'hC, 32'h0},
    {1'b1, 5'd16, 4'h2, 32'h0000EE00},
    {1'b0, 5'd16, 4'h1, 32'h0},
    {1'b1, 5'd20, 4'h0, 32'hFFFFFFFF},
    {1'b0, 5'd22, 4'hF, 32'h0},
    {1'b1, 5'd28, 4'h9, 32'h77BBCC66},
    {1'b0, 5'd28, 4'hF, 32'h0}
  };

  task automatic access(input logic we, input logic [4:0] adr, input logic [3:0] sel,
                        input logic [31:0] wd, input bit hold);
    logic [31:0] rd, exp;
    int exp_rd, exp_wr, t;
    logic [19:0] exp_first;
    logic [2:0] w;
    w = adr[4:2];
    exp_rd = 0; exp_wr = 0;
    for (int h = 0; h < 2; h++) begin
      logic [1:0] p;
      p = sel[2*h +: 2];
      if (p != 2'b00) begin
        if (!we || p != 2'b11) exp_rd++;
        if (we) exp_wr++;
      end
    end
    exp = 32'h0;
    if (sel[1:0] != 0) exp[15:0]  = {refm[4*w+1], refm[4*w]};
    if (sel[3:2] != 0) exp[31:16] = {refm[4*w+3], refm[4*w+2]};
    exp_first = {16'h0, w, (sel[1:0] == 2'b00)};
    @(negedge clk);
    n_rd = 0; n_wr = 0; n_log = 0; n_ack = 0; last_dn = -10; ack_cyc = -20;
    up_cyc = 1; up_stb = 1; up_we = we; up_adr = {16'h0, adr}; up_sel = sel; up_wdat = wd;
    t = 0;
    while (up_stall && t < 100) begin @(negedge clk); t++; end
    @(negedge clk);
    if (!hold) up_stb = 0;
    if (sel != 0) chk(up_stall, "R7", "stall after accept", {31'h0, up_stall}, 32'h1);
    t = 0;
    while (!up_ack && t < 100) begin @(negedge clk); t++; end
    rd = up_rdat;
    up_stb = 0; up_cyc = 0;
    repeat (3) @(negedge clk);
    chk(n_ack == 1, "R6", "ack count", n_ack, 1);
    chk(n_rd == exp_rd, we ? "R5" : "R2", "narrow reads", n_rd, exp_rd);
    chk(n_wr == exp_wr, "R4", "narrow writes", n_wr, exp_wr);
    if (sel == 0) begin
      chk(n_rd + n_wr == 0, "R9", "no narrow access", n_rd + n_wr, 0);
      if (!we) chk(rd == 0, "R9", "rdat zero", rd, 0);
    end else begin
      chk(ack_cyc == last_dn + 1, "R6", "ack timing", ack_cyc - last_dn, 1);
      chk(log_adr[0] == exp_first, "R10", "first address", {12'h0, log_adr[0]}, {12'h0, exp_first});
      if (!we) chk(rd == exp, (sel == 4'hF) ? "R2" : "R3", "read data", rd, exp);
      if (sel == 4'hF && !we)
        chk(log_adr[1] == exp_first + 1, "R2", "second address", {12'h0, log_adr[1]}, {12'h0, exp_first + 20'd1});
      if (we && sel[1:0] != 0 && ^sel[1:0])
        chk(!log_we[0] && log_we[1], "R5", "read before write", {log_we[0], log_we[1]}, 2'b01);
    end
    if (we) for (int b = 0; b < 4; b++) if (sel[b]) refm[4*w+b] = wd[8*b +: 8];
  endtask

  initial begin
    for (int b = 0; b < 32; b++) refm[b] = 8'(b * 7 + 3);
    for (int k = 0; k < 16; k++) smem[k] = {8'((2*k+1) * 7 + 3), 8'((2*k) * 7 + 3)};
    repeat (3) @(negedge clk);
    chk(!up_ack && !up_stall && !dn_cyc && !dn_stb, "R1", "outputs in reset",
        {up_ack, up_stall, dn_cyc, dn_stb}, 0);
    rst = 0;
    @(negedge clk);
    chk(!up_ack && !up_stall && !dn_cyc && !dn_stb, "R1", "outputs after reset",
        {up_ack, up_stall, dn_cyc, dn_stb}, 0);
    for (int pass = 0; pass < 2; pass++) begin
      stall_en = (pass == 1);  // R8 pass with narrow stall
      for (int i = 0; i < 13; i++)
        access(VEC[i][41], VEC[i][40:36], VEC[i][35:32], VEC[i][31:0], 1'b0);
    end
    stall_en = 0;
    access(1'b0, 5'd0, 4'hF, 32'h0, 1'b1);   // R7 strobe held through access
    stall_en = 1;
    access(1'b1, 5'd24, 4'h2, 32'h00009900, 1'b1);
    access(1'b0, 5'd26, 4'h3, 32'h0, 1'b0);  // R10 low bits ignored, R8
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule